// File: doc/BRIEF.md
# Video-Address Edge Interrupt Generator

This block produces a periodic interrupt for a game cartridge. It watches bit 12 of the video-bus address. That line toggles at a steady rate while the picture is drawn, so its falling edges serve as a time base. Each falling edge advances a free-running binary counter. The active-low interrupt request follows one bit of that counter. The request therefore goes low after 32 edges and goes high again after 32 more, and this repeats for as long as edges arrive.

The block has no enable and no reload value. Software acknowledges the interrupt, and restarts the period, with a single CPU write to one decoded address in the $F000 region. That write clears the counter. Software that does not want the interrupt must mask it inside the CPU. The video-address line runs asynchronously to the block clock, so it is resynchronised before its edges are detected.

Top module: `edge_irq_gen`

## Requirements
- R1: Each falling edge of `vid_a12` advances the internal count by one. Rising edges and steady levels do not advance it. An edge reaches the count on the third rising `clk` edge after it is first sampled. There are two synchronizer stages, and the count register then updates.
- R2: `irq_n` is low exactly while bit 5 of the count is 1. After a clear, it goes low once 32 falling edges have been counted.
- R3: If it is not acknowledged, `irq_n` returns high after 32 further edges (64 in total) and keeps alternating every 32 edges. The count is 14 bits and wraps modulo 16384.
- R4: A clear happens when all of these hold in one cycle: `cpu_rw` = 0, `rom_sel_n` = 0, `cpu_addr_hi` = 3'b111 (A14, A13, A12 all high) and `cpu_addr_lo[3:2]` = 2'b10 (for example $F008). On the next clock edge the count becomes 0 and `irq_n` is high.
- R5: A write with `cpu_addr_lo[3:2]` = 2'b11 (for example $F00C) leaves the count unchanged. So do a read (`cpu_rw` = 1), `rom_sel_n` = 1, and any `cpu_addr_hi` other than 3'b111.
- R6: If a clear and a detected falling edge fall in the same cycle, the clear wins and the count becomes 0.
- R7: A synchronous active-high `rst` zeroes the count and the synchronizer. `irq_n` is high in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_a12 | input | 1 | Video-bus address bit 12, asynchronous |
| cpu_rw | input | 1 | CPU read/write, 0 = write |
| rom_sel_n | input | 1 | Active-low ROM select |
| cpu_addr_hi | input | 3 | CPU address bits A14..A12 |
| cpu_addr_lo | input | 4 | CPU address bits A3..A0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
An acknowledge write and a detected falling edge can both land on the counter in the same clock. The bench provokes this by sliding a one-cycle acknowledge write across every cycle offset around a falling edge of `vid_a12`. It then counts out the following 32 edges, so that a count left one higher or one lower shows up as an early or late change of `irq_n`. A behavioural model reaches its own verdict for each offset, and `irq_n` is compared with that model on every clock.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  parameter int unsigned DEF_CNT_W   = 14;
  parameter int unsigned DEF_IRQ_BIT = 5;
  parameter int unsigned DEF_SYNC_N  = 2;
  parameter int unsigned LO_W        = 4;
  parameter int unsigned HI_W        = 3;

  typedef struct packed {
    logic            rw;
    logic            sel_n;
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
  } cpu_bus_t;
endpackage

// File: rtl/a12_fall_detect.sv
module a12_fall_detect #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic fall_o
);
  localparam int unsigned TAPS = SYNC_N + 1;

  logic [TAPS-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[TAPS-2:0], async_i};
  end

  // previous synchronised sample high, current low
  assign fall_o = pipe_q[TAPS-1] & ~pipe_q[TAPS-2];

  // R1: a falling edge needs a high sample in between, so two never abut
  a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ack_decode.sv
module ack_decode
  import edge_irq_pkg::*;
#(
  parameter logic [1:0] ACK_SEL = 2'b10
) (
  input  cpu_bus_t bus_i,
  output logic     clr_o
);
  logic space_hit;

  assign space_hit = ~bus_i.rw & ~bus_i.sel_n & (&bus_i.hi);
  assign clr_o     = space_hit & (bus_i.lo[3:2] == ACK_SEL);

  // R5: the neighbouring $F00C slot never acknowledges
  always_comb begin
    a_r5_f00c_ignored: assert (!(bus_i.lo[3:2] == 2'b11 && clr_o));
  end
endmodule

// File: rtl/edge_counter.sv
module edge_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R6 / R4: a clear always lands as zero, even with a step pending
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
  // R1: one edge, one increment, wrapping modulo the width (R3)
  a_r1_step_one: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clr_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R5: with no edge and no clear the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/edge_irq_gen.sv
module edge_irq_gen
  import edge_irq_pkg::*;
#(
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned IRQ_BIT = DEF_IRQ_BIT,
  parameter int unsigned SYNC_N  = DEF_SYNC_N
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vid_a12,
  input  logic            cpu_rw,
  input  logic            rom_sel_n,
  input  logic [HI_W-1:0] cpu_addr_hi,
  input  logic [LO_W-1:0] cpu_addr_lo,
  output logic            irq_n
);
  cpu_bus_t         bus;
  logic             fall;
  logic             clr;
  logic [CNT_W-1:0] cnt;

  assign bus = '{rw: cpu_rw, sel_n: rom_sel_n, hi: cpu_addr_hi, lo: cpu_addr_lo};

  a12_fall_detect #(.SYNC_N(SYNC_N)) u_fall (
    .clk     (clk),
    .rst     (rst),
    .async_i (vid_a12),
    .fall_o  (fall)
  );

  ack_decode u_dec (
    .bus_i (bus),
    .clr_o (clr)
  );

  edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .step_i (fall),
    .clr_i  (clr),
    .cnt_o  (cnt)
  );

  assign irq_n = ~cnt[IRQ_BIT];

  // R7: request released after reset
  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> irq_n);
  // R2: the request only moves after an edge or a clear
  a_r2_moves_on_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(irq_n) |-> $past(fall || clr));
  // R4: an acknowledge always leaves the request released
  a_r4_ack_releases: assert property (@(posedge clk) disable iff (rst)
    clr |=> irq_n);
endmodule

// File: tb/edge_irq_gen_bench.sv
module edge_irq_gen_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vid_a12 = 1'b0;
  logic       cpu_rw = 1'b1;
  logic       rom_sel_n = 1'b1;
  logic [2:0] cpu_addr_hi = 3'b000;
  logic [3:0] cpu_addr_lo = 4'h0;
  logic       irq_n;

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  string tag = "R7";

  // behavioural reference
  bit  hist[$] = '{0, 0, 0};
  int  m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_gen u_edge_irq_gen (
    .clk         (clk),
    .rst         (rst),
    .vid_a12     (vid_a12),
    .cpu_rw      (cpu_rw),
    .rom_sel_n   (rom_sel_n),
    .cpu_addr_hi (cpu_addr_hi),
    .cpu_addr_lo (cpu_addr_lo),
    .irq_n       (irq_n)
  );

  always @(posedge clk) begin
    bit fell;
    bit ack;
    cycles++;
    if (rst) begin
      m_cnt = 0;
      hist = '{0, 0, 0};
    end else begin
      fell = hist[2] && !hist[1];
      ack  = !cpu_rw && !rom_sel_n && cpu_addr_hi == 3'b111 && cpu_addr_lo[3:2] == 2'b10;
      if (ack)       m_cnt = 0;
      else if (fell) m_cnt = (m_cnt + 1) % 16384;
      hist.push_front(vid_a12);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    logic exp_irq;
    exp_irq = ((m_cnt >> 5) & 1) ? 1'b0 : 1'b1;
    vectors++;
    if (irq_n !== exp_irq) begin
      miscompares++;
      $display("FAIL %s cycle %0d: irq_n actual %b expected %b", tag, cycles, irq_n, exp_irq);
    end
  end

  always @(negedge clk) begin
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin
      vid_a12 = 1'b1; idle(2);
      vid_a12 = 1'b0; idle(2);
    end
  endtask

  task automatic bus_cycle(logic rw, logic sel_n, logic [2:0] hi, logic [3:0] lo);
    cpu_rw = rw; rom_sel_n = sel_n; cpu_addr_hi = hi; cpu_addr_lo = lo;
    idle(1);
    cpu_rw = 1'b1; rom_sel_n = 1'b1; cpu_addr_hi = 3'b000; cpu_addr_lo = 4'h0;
  endtask

  initial begin
    tag = "R7";
    idle(3);
    rst = 1'b0;
    idle(3);

    tag = "R1";
    vid_a12 = 1'b1; idle(10);          // level and rise only
    vid_a12 = 1'b0; idle(6);

    tag = "R2";
    edges(40);                         // crosses 32
    tag = "R3";
    edges(100);                        // de-assert at 64, repeat at 96, 128

    tag = "R4";
    bus_cycle(1'b0, 1'b0, 3'b111, 4'h8);   // acknowledge at $F008
    idle(4);
    edges(33);
    bus_cycle(1'b0, 1'b0, 3'b111, 4'hB);   // $F00B also acknowledges
    idle(4);

    tag = "R5";
    edges(31);
    bus_cycle(1'b0, 1'b0, 3'b111, 4'hC);   // $F00C ignored
    bus_cycle(1'b1, 1'b0, 3'b111, 4'h8);   // read ignored
    bus_cycle(1'b0, 1'b1, 3'b111, 4'h8);   // ROM not selected
    bus_cycle(1'b0, 1'b0, 3'b011, 4'h8);   // A14 low
    bus_cycle(1'b0, 1'b0, 3'b110, 4'h8);   // A12 low
    edges(2);                              // count reaches 33: request low

    tag = "R6";
    for (int off = 0; off < 6; off++) begin
      vid_a12 = 1'b1; idle(4);
      vid_a12 = 1'b0; idle(off);
      bus_cycle(1'b0, 1'b0, 3'b111, 4'h8);
      idle(4);
      edges(33);
    end

    tag = "R3";
    edges(16400);                      // wrap of the 14-bit count

    tag = "R7";
    rst = 1'b1; idle(2);
    rst = 1'b0; idle(4);
    edges(33);

    idle(4);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule